// File: doc/BRIEF.md
# SECDED Read-Path Guard with First-Error Capture

This block sits on the read path of a memory that keeps each 64-bit data word with eight check bits. It decodes every 72-bit codeword that arrives with a valid strobe. It fixes any single flipped bit and flags double flips. One clock later it presents the repaired word. A matching combinational encoder builds codewords for the write path.

A small status register holds the address and the requesting master of the first error that was reported. It also holds two sticky flags and an enable bit for the correction interrupt. Software clears each flag by writing 1 to it.

A two-state capture machine guards the register:
- **CAP_OPEN**: the flags are clear. Any reported error records its address and master ID and takes the transition *capture* to **CAP_HELD**.
- **CAP_HELD**: later errors leave the register untouched. The transition *release* back to CAP_OPEN is taken once software has cleared both flags.

A word whose 64 data bits are all ones is treated as erased. Single errors in it are still repaired, but double-error reporting is suppressed.

Top module: `secded_guard`

## Requirements
- R1: Codeword layout. Bits [63:0] hold the data. Bit 64+k holds Hamming check k, the XOR of the data bits whose position has bit k set. Data bit i sits at the i-th position in 1..71 that is not a power of two. Bit 71 makes the XOR of all 72 bits zero. A codeword that matches returns its data unchanged and reports no error.
- R2: A single flipped data bit is repaired in `rd_data` and sets the single flag (status bit 30).
- R3: A single flipped check bit (bits 64..71) returns the data unchanged and sets the single flag.
- R4: A double flip sets the double flag (status bit 31), and `fatal_pulse` is high for the one cycle after that read. The pulse is raised on every double error, including while the flags are held.
- R5: `corr_irq` is high exactly when the single flag is set and the enable bit (status bit 24, read/write) is 1.
- R6: When an error is captured, status bits [16:0] take the read address with bits [2:0] forced to zero, and bits [19:17] take the master ID.
- R7: While either flag is set, later errors change neither the flags, nor the address, nor the ID. Capture resumes only after both flags are clear.
- R8: If the received data bits are all ones and the syndrome indicates a double error, no flag is set, no pulse is raised, and the data is returned as all ones. A single data-bit flip in an erased word is still repaired.
- R9: Writing 1 to status bit 30 or 31 clears that flag. An error captured in the same cycle as a clear wins.
- R10: `rd_data` and `rd_data_valid` are registered: they appear in the cycle after `rd_valid`, and `rd_data_valid` is high for one cycle per read.
- R11: After reset, the status register reads zero, and `rd_data_valid`, `corr_irq` and `fatal_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 64 | Data to encode |
| wr_code | output | 72 | Encoded codeword |
| rd_valid | input | 1 | Read codeword strobe |
| rd_code | input | 72 | Codeword read from storage |
| rd_addr | input | 17 | Address of the read |
| rd_master | input | 3 | ID of the requesting master |
| rd_data | output | 64 | Corrected data, registered |
| rd_data_valid | output | 1 | `rd_data` is valid |
| csr_wr_en | input | 1 | Status register write strobe |
| csr_wdata | input | 32 | Status register write data |
| csr_rdata | output | 32 | Status register contents |
| corr_irq | output | 1 | Correction interrupt |
| fatal_pulse | output | 1 | Non-maskable double-error pulse |

## Verification
The assertions assume that `rd_valid` is a clean strobe and that the address and master ID are steady whenever it is high. The stimulus changes all inputs only on falling edges and holds each read for exactly one cycle. The assertions do not reason about codewords with three or more flips, whose class is undefined. The stimulus therefore flips at most two distinct bits of a correctly encoded word. Status writes are made as single-cycle strobes; one of them deliberately shares a cycle with an error to exercise the set-over-clear rule.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned CHK_W  = 7;
    localparam int unsigned CODE_W = DATA_W + CHK_W + 1;
    localparam int unsigned POS_MAX = CODE_W - 1;

    typedef enum logic [1:0] {
        ECC_CLEAN,
        ECC_SINGLE,
        ECC_DOUBLE,
        ECC_ERASED
    } ecc_class_e;

    typedef enum logic {
        CAP_OPEN,
        CAP_HELD
    } cap_state_e;

    // Hamming position of data bit idx: idx-th non power of two in 1..POS_MAX
    function automatic logic [CHK_W-1:0] data_pos(input int idx);
        logic [CHK_W-1:0] res;
        int seen;
        res  = '0;
        seen = 0;
        for (int q = 1; q <= int'(POS_MAX); q++) begin
            if ((q & (q - 1)) != 0) begin
                if (seen == idx) res = CHK_W'(q);
                seen++;
            end
        end
        return res;
    endfunction

    function automatic logic [CHK_W-1:0] hamming_chk(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        logic [CHK_W-1:0] p;
        c = '0;
        for (int i = 0; i < int'(DATA_W); i++) begin
            p = data_pos(i);
            for (int k = 0; k < int'(CHK_W); k++) begin
                if (p[k]) c[k] = c[k] ^ d[i];
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    logic [CHK_W-1:0] chk;

    always_comb begin
        chk      = hamming_chk(data_in);
        code_out = {^{chk, data_in}, chk, data_in};
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output ecc_class_e        cls
);
    logic [CHK_W-1:0]  syn;
    logic              par_odd;
    logic              erased;
    logic              syn_pow2;
    logic [DATA_W-1:0] fix;

    always_comb begin
        syn      = hamming_chk(code_in[DATA_W-1:0]) ^ code_in[DATA_W +: CHK_W];
        par_odd  = ^code_in;
        erased   = &code_in[DATA_W-1:0];
        syn_pow2 = ((syn & (syn - 1'b1)) == '0);
        fix      = '0;
        cls      = ECC_CLEAN;
        if (syn == '0 && !par_odd) begin
            cls = ECC_CLEAN;
        end else if (par_odd && syn <= CHK_W'(POS_MAX)) begin
            cls = ECC_SINGLE;
            if (!syn_pow2) begin
                for (int i = 0; i < int'(DATA_W); i++) begin
                    if (data_pos(i) == syn) fix[i] = 1'b1;
                end
            end
        end else begin
            cls = erased ? ECC_ERASED : ECC_DOUBLE;
        end
        data_out = code_in[DATA_W-1:0] ^ fix;
    end
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
    import secded_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned ID_W      = 3,
    parameter int unsigned ALIGN_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_single,
    input  logic              evt_double,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [ID_W-1:0]   evt_id,
    input  logic              csr_wr_en,
    input  logic              wr_irq_en,
    input  logic              wr_clr_single,
    input  logic              wr_clr_double,
    output logic              flag_single,
    output logic              flag_double,
    output logic              irq_en,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [ID_W-1:0]   cap_id
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_LSB) - 1);

    cap_state_e cap_state, cap_next;
    logic       evt_any;
    logic       keep_single, keep_double;

    assign evt_any     = evt_single | evt_double;
    assign keep_single = flag_single & ~(csr_wr_en & wr_clr_single);
    assign keep_double = flag_double & ~(csr_wr_en & wr_clr_double);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_state <= CAP_OPEN;
        else        cap_state <= cap_next;
    end

    always_comb begin
        cap_next = cap_state;
        unique case (cap_state)
            CAP_OPEN: if (evt_any) cap_next = CAP_HELD;                      // capture
            CAP_HELD: if (!keep_single && !keep_double) cap_next = CAP_OPEN; // release
            default:  cap_next = CAP_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_single <= 1'b0;
            flag_double <= 1'b0;
            irq_en      <= 1'b0;
            cap_addr    <= '0;
            cap_id      <= '0;
        end else begin
            if (csr_wr_en) irq_en <= wr_irq_en;
            unique case (cap_state)
                CAP_OPEN: begin
                    if (evt_any) begin
                        flag_single <= evt_single;
                        flag_double <= evt_double;
                        cap_addr    <= evt_addr & ALIGN_MASK;
                        cap_id      <= evt_id;
                    end
                end
                CAP_HELD: begin
                    flag_single <= keep_single;
                    flag_double <= keep_double;
                end
                default: ;
            endcase
        end
    end

    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == CAP_HELD) |=> ($stable(cap_addr) && $stable(cap_id))); // R7
    AST_OPEN_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == CAP_OPEN) |-> (!flag_single && !flag_double)); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == CAP_OPEN && evt_any) |=> (flag_single || flag_double)); // R9
endmodule

// File: rtl/secded_guard.sv
module secded_guard
    import secded_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned ID_W      = 3,
    parameter int unsigned ALIGN_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       wr_data,
    output logic [71:0]       wr_code,
    input  logic              rd_valid,
    input  logic [71:0]       rd_code,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ID_W-1:0]   rd_master,
    output logic [63:0]       rd_data,
    output logic              rd_data_valid,
    input  logic              csr_wr_en,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              corr_irq,
    output logic              fatal_pulse
);
    localparam int unsigned EN_BIT  = 24;
    localparam int unsigned SGL_BIT = 30;
    localparam int unsigned DBL_BIT = 31;

    logic [DATA_W-1:0] dec_data;
    ecc_class_e        dec_cls;
    logic              flag_single, flag_double, irq_en;
    logic [ADDR_W-1:0] cap_addr;
    logic [ID_W-1:0]   cap_id;
    logic              evt_single, evt_double;

    secded_enc u_enc (.data_in(wr_data), .code_out(wr_code));
    secded_dec u_dec (.code_in(rd_code), .data_out(dec_data), .cls(dec_cls));

    assign evt_single = rd_valid && (dec_cls == ECC_SINGLE);
    assign evt_double = rd_valid && (dec_cls == ECC_DOUBLE);

    ecc_capture #(.ADDR_W(ADDR_W), .ID_W(ID_W), .ALIGN_LSB(ALIGN_LSB)) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_single    (evt_single),
        .evt_double    (evt_double),
        .evt_addr      (rd_addr),
        .evt_id        (rd_master),
        .csr_wr_en     (csr_wr_en),
        .wr_irq_en     (csr_wdata[EN_BIT]),
        .wr_clr_single (csr_wdata[SGL_BIT]),
        .wr_clr_double (csr_wdata[DBL_BIT]),
        .flag_single   (flag_single),
        .flag_double   (flag_double),
        .irq_en        (irq_en),
        .cap_addr      (cap_addr),
        .cap_id        (cap_id)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data       <= '0;
            rd_data_valid <= 1'b0;
            fatal_pulse   <= 1'b0;
        end else begin
            rd_data_valid <= rd_valid;
            fatal_pulse   <= evt_double;
            if (rd_valid) rd_data <= dec_data;
        end
    end

    always_comb begin
        csr_rdata                         = '0;
        csr_rdata[ADDR_W-1:0]             = cap_addr;
        csr_rdata[ADDR_W +: ID_W]         = cap_id;
        csr_rdata[EN_BIT]                 = irq_en;
        csr_rdata[SGL_BIT]                = flag_single;
        csr_rdata[DBL_BIT]                = flag_double;
    end

    assign corr_irq = flag_single & irq_en;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_data_valid); // R10
    AST_PULSE_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_pulse |-> $past(rd_valid)); // R4
endmodule

// File: tb/test_secded_guard.sv
module test_secded_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wr_data = '0;
    logic [71:0] wr_code;
    logic        rd_valid = 1'b0;
    logic [71:0] rd_code = '0;
    logic [16:0] rd_addr = '0;
    logic [2:0]  rd_master = '0;
    logic [63:0] rd_data;
    logic        rd_data_valid;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        corr_irq;
    logic        fatal_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    secded_guard i_secded_guard (.*);

    // {data, flip_a, flip_b, class}; flip 127 = none; class 0 clean 1 single 2 double 3 erased-suppressed
    localparam logic [79:0] VEC [10] = '{
        {64'h0123_4567_89AB_CDEF, 7'd127, 7'd127, 2'd0},
        {64'h0123_4567_89AB_CDEF, 7'd0,   7'd127, 2'd1},
        {64'hDEAD_BEEF_0000_FFFF, 7'd63,  7'd127, 2'd1},
        {64'h5555_AAAA_3333_CCCC, 7'd66,  7'd127, 2'd1},
        {64'h5555_AAAA_3333_CCCC, 7'd71,  7'd127, 2'd1},
        {64'h0000_0000_0000_0000, 7'd5,   7'd40,  2'd2},
        {64'hFFFF_FFFF_FFFF_FFFF, 7'd64,  7'd65,  2'd3},
        {64'hFFFF_FFFF_FFFF_FFFF, 7'd12,  7'd127, 2'd1},
        {64'h8000_0000_0000_0001, 7'd70,  7'd10,  2'd2},
        {64'hFFFF_FFFF_FFFF_FFFF, 7'd127, 7'd127, 2'd0}
    };

    function automatic logic [71:0] ref_encode(input logic [63:0] d);
        logic [71:1] h;
        logic [6:0]  chk;
        int          j;
        h = '0;
        j = 0;
        for (int p = 1; p <= 71; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
                h[p] = d[j];
                j++;
            end
        end
        chk = '0;
        for (int p = 1; p <= 71; p++) begin
            for (int k = 0; k < 7; k++) begin
                if (((p >> k) & 1) == 1) chk[k] = chk[k] ^ h[p];
            end
        end
        return {^{chk, d}, chk, d};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [31:0] w);
        @(negedge clk);
        csr_wr_en = 1'b1;
        csr_wdata = w;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [71:0] c, input logic [16:0] a, input logic [2:0] m);
        @(negedge clk);
        rd_valid  = 1'b1;
        rd_code   = c;
        rd_addr   = a;
        rd_master = m;
        @(negedge clk);
        rd_valid  = 1'b0;
    endtask

    function automatic logic [71:0] flip(input logic [71:0] c, input logic [6:0] a, input logic [6:0] b);
        logic [71:0] r;
        r = c;
        if (a != 7'd127) r[a] = ~r[a];
        if (b != 7'd127) r[b] = ~r[b];
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 status", 64'(csr_rdata), 64'h0);
        check("R11 valid", 64'(rd_data_valid), 64'h0);
        check("R11 irq", 64'(corr_irq), 64'h0);
        check("R11 pulse", 64'(fatal_pulse), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 status after release", 64'(csr_rdata), 64'h0);

        // R1 encoder output
        wr_data = 64'hCAFE_F00D_1234_5678;
        #1;
        check("R1 encoder low", wr_code[63:0], ref_encode(wr_data)[63:0]);
        check("R1 encoder chk", 64'(wr_code[71:64]), 64'(ref_encode(wr_data)[71:64]));

        // vector table: R1 R2 R3 R4 R5 R6 R8 R10
        for (int i = 0; i < 10; i++) begin
            logic [63:0] d;
            logic [6:0]  fa, fb;
            logic [1:0]  cl;
            logic [16:0] a;
            logic [2:0]  m;
            {d, fa, fb, cl} = VEC[i];
            a = 17'h00015 + 17'(i * 37);
            m = 3'(i);
            csr_write(32'hC100_0000);
            do_read(flip(ref_encode(d), fa, fb), a, m);
            check("R10 valid after read", 64'(rd_data_valid), 64'h1);
            if (cl != 2'd2) check("R2/R3/R8 data", rd_data, d);
            check("R2/R4/R8 flags", 64'(csr_rdata[31:30]),
                  64'(cl == 2'd1 ? 2'b01 : cl == 2'd2 ? 2'b10 : 2'b00));
            check("R4/R8 pulse", 64'(fatal_pulse), 64'(cl == 2'd2));
            check("R5 irq", 64'(corr_irq), 64'(cl == 2'd1));
            if (cl == 2'd1 || cl == 2'd2) begin
                check("R6 addr", 64'(csr_rdata[16:0]), 64'(a & 17'h1FFF8));
                check("R6 id", 64'(csr_rdata[19:17]), 64'(m));
            end
            @(negedge clk);
            check("R10 one-cycle valid", 64'(rd_data_valid), 64'h0);
            check("R4 pulse one cycle", 64'(fatal_pulse), 64'h0);
        end

        // R7 hold while flagged
        csr_write(32'hC100_0000);
        do_read(flip(ref_encode(64'h1111_2222_3333_4444), 7'd9, 7'd127), 17'h1ABCD, 3'd5);
        check("R6 addr aligned", 64'(csr_rdata[16:0]), 64'h1ABC8);
        do_read(flip(ref_encode(64'h1111_2222_3333_4444), 7'd9, 7'd20), 17'h00100, 3'd2);
        check("R4 pulse while held", 64'(fatal_pulse), 64'h1);
        check("R7 flags frozen", 64'(csr_rdata[31:30]), 64'h1);
        check("R7 addr frozen", 64'(csr_rdata[16:0]), 64'h1ABC8);
        check("R7 id frozen", 64'(csr_rdata[19:17]), 64'h5);
        csr_write(32'h4100_0000);
        check("R9 clear single", 64'(csr_rdata[31:30]), 64'h0);
        do_read(flip(ref_encode(64'h1111_2222_3333_4444), 7'd9, 7'd20), 17'h00100, 3'd2);
        check("R7 capture resumes flags", 64'(csr_rdata[31:30]), 64'h2);
        check("R7 capture resumes addr", 64'(csr_rdata[16:0]), 64'h00100);
        check("R7 capture resumes id", 64'(csr_rdata[19:17]), 64'h2);

        // R9 set beats clear in the same cycle
        csr_write(32'hC100_0000);
        @(negedge clk);
        csr_wr_en = 1'b1;
        csr_wdata = 32'hC100_0000;
        rd_valid  = 1'b1;
        rd_code   = flip(ref_encode(64'h7), 7'd1, 7'd127);
        rd_addr   = 17'h00040;
        rd_master = 3'd6;
        @(negedge clk);
        csr_wr_en = 1'b0;
        rd_valid  = 1'b0;
        check("R9 set wins", 64'(csr_rdata[31:30]), 64'h1);
        check("R2 data repaired", rd_data, 64'h7);

        // R5 enable gating
        csr_write(32'h0000_0000);
        check("R5 irq masked", 64'(corr_irq), 64'h0);
        check("R5 flag kept", 64'(csr_rdata[30]), 64'h1);
        csr_write(32'h0100_0000);
        check("R5 irq enabled", 64'(corr_irq), 64'h1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule